// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block steers accesses that fall in the legacy window between 640 KB and 1 MB. Software programs eight configuration bytes through a byte-wide write port: seven attribute bytes that give each legacy region a 2-bit routing code, and one control byte for the graphics area at 0xA0000–0xBFFFF. The block keeps a decoded routing table built from those bytes and from a system-management-mode (SMM) input. For every lookup it reports whether the access goes to system DRAM or is forwarded to the I/O bus.

The range 0xC0000–0xEFFFF is cut into twelve 16 KB segments. Each segment has its own code. The 64 KB region at 0xF0000 has one shared code. The graphics area has no code. It opens to DRAM when a force bit is set, or when SMM is active and an SMM-enable bit is set. A routing code can send reads and writes to different sides, which lets firmware shadow a ROM into DRAM.

A configuration write to one of the eight decoded offsets, or a change on the SMM input, starts a rebuild of the routing table. Lookups are pipelined with one register stage. Addresses outside the legacy window always select DRAM.

Top module: `legacy_attr_decoder`

## Requirements
- R1: After reset, every attribute byte is zero and the control byte at offset 0x72 is 0x02, so every lookup in 0xA0000–0xFFFFF is forwarded to the I/O bus (rspDram = 0).
- R2: Bits 5:4 of the byte at offset 0x59 hold the code for the whole 0xF0000–0xFFFFF region. The other bits of that byte have no effect on routing.
- R3: Segment s (0..11) covers 0xC0000 + s·0x4000 up to the next 16 KB boundary. Its code is in byte 0x5A + s/2: bits 1:0 for even s and bits 5:4 for odd s. Bits 3:2 and 7:6 of those bytes have no effect.
- R4: Code bit 0 sends reads to DRAM and code bit 1 sends writes to DRAM. A clear bit forwards that direction to the bus. Code 3 is full DRAM, code 1 is DRAM for reads only, code 2 is DRAM for writes only, and code 0 forwards both.
- R5: Reads and writes to 0xA0000–0xBFFFF go to DRAM when bit 6 of the control byte at 0x72 is 1, or when SMM is active and bit 3 of that byte is 1. Otherwise they go to the bus.
- R6: A change on smmActive rebuilds the graphics-area routing with no configuration write.
- R7: Addresses below 0xA0000 or at 0x100000 and above select DRAM whatever the register contents, including addresses whose low 20 bits fall inside the legacy window.
- R8: Each lookup sampled at a clock edge gives exactly one response, valid after that same edge. A configuration write or smmActive change sampled at edge k affects lookups sampled at edge k+2 onward. Lookups sampled at edge k+1 still see the previous routing.
- R9: Writes to any offset other than 0x59–0x5F and 0x72 change no routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgData | input | 8 | Configuration byte value |
| smmActive | input | 1 | System-management mode is active |
| reqValid | input | 1 | Lookup request valid |
| reqAddr | input | ADDR_W | Lookup address |
| reqWrite | input | 1 | Lookup is a write (1) or a read (0) |
| rspValid | output | 1 | Lookup response valid, one cycle after the request |
| rspDram | output | 1 | 1 = route to DRAM, 0 = forward to the I/O bus |

## Verification
The bench fills all twelve segments with distinct read/write codes and sets the unused nibble bits to ones, then probes the first and last byte of every segment in both directions. A design that swapped nibbles, mis-ordered bytes or read the wrong bit pair would route some segment the wrong way. The bench also sends aliasing addresses above 1 MB whose low bits land in a forwarded segment; a design that decoded only the low 20 bits would forward them. It writes all-ones to the offsets around the decoded bytes, which would open regions in a design with a loose offset compare. Finally, it times lookups one and two edges after a write and after an SMM toggle, which exposes a table that rebuilds too early, too late or never on an SMM change.

// File: rtl/legacy_attr_pkg.sv
package legacy_attr_pkg;

  // Width of the attribute byte index (seven bytes)
  localparam int ATTR_IDX_W = 3;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic                  wrAttr;   // store cfgData into an attribute byte
    logic                  wrSmram;  // store cfgData into the window control byte
    logic [ATTR_IDX_W-1:0] attrIdx;  // attribute byte being written
    logic                  remap;    // rebuild the routing table this cycle
    logic                  smmState; // registered SMM state used by the rebuild
  } ctlStrobe_t;

endpackage

// File: rtl/legacy_attr_ctrl.sv
module legacy_attr_ctrl
  import legacy_attr_pkg::*;
#(
  parameter logic [7:0] ATTR_BASE  = 8'h59,
  parameter int         ATTR_BYTES = 7,
  parameter logic [7:0] SMRAM_OFF  = 8'h72
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgAddr,
  input  logic       smmActive,
  output ctlStrobe_t strobe
);

  localparam logic [7:0] ATTR_SPAN = 8'(ATTR_BYTES);

  logic [7:0] relOff;
  logic       hitAttr;
  logic       hitSmram;
  logic       smmQ;
  logic       remapQ;

  // Unsigned wrap makes offsets below the base fail the span compare
  assign relOff   = cfgAddr - ATTR_BASE;
  assign hitAttr  = cfgWrEn && (relOff < ATTR_SPAN);
  assign hitSmram = cfgWrEn && (cfgAddr == SMRAM_OFF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smmQ   <= 1'b0;
      remapQ <= 1'b0;
    end else begin
      smmQ   <= smmActive;
      remapQ <= hitAttr || hitSmram || (smmActive != smmQ);
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.wrAttr   = hitAttr;
    strobe.wrSmram  = hitSmram;
    strobe.attrIdx  = relOff[ATTR_IDX_W-1:0];
    strobe.remap    = remapQ;
    strobe.smmState = smmQ;
  end

endmodule

// File: rtl/legacy_attr_dp.sv
module legacy_attr_dp
  import legacy_attr_pkg::*;
#(
  parameter int         ADDR_W     = 32,
  parameter int         ATTR_BYTES = 7,
  parameter int         NUM_SEG    = 12,
  parameter logic [7:0] SMRAM_RST  = 8'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [7:0]        cfgData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  output logic              rspValid,
  output logic              rspDram
);

  localparam int WIN_TOP_BIT   = 20;  // legacy window lies below 1 MB
  localparam int SEG_LSB       = 14;  // 16 KB segments
  localparam int SEG_IDX_W     = 4;
  localparam int TOP_CODE_LSB  = 4;
  localparam int FORCE_BIT     = 6;
  localparam int SMM_GATE_BIT  = 3;

  logic [ATTR_BYTES-1:0][7:0] attrQ;
  logic [7:0]                 smramQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attrQ  <= '0;
      smramQ <= SMRAM_RST;
    end else begin
      if (strobe.wrAttr)  attrQ[strobe.attrIdx] <= cfgData;
      if (strobe.wrSmram) smramQ <= cfgData;
    end
  end

  // Next routing table, one read bit and one write bit per region
  logic [NUM_SEG-1:0] segRdNext, segWrNext;
  logic               topRdNext, topWrNext, winNext;

  for (genvar s = 0; s < NUM_SEG; s++) begin : gSeg
    localparam int BYTE_SEL = 1 + s / 2;
    localparam int NIB_LSB  = (s % 2) * 4;
    assign segRdNext[s] = attrQ[BYTE_SEL][NIB_LSB];
    assign segWrNext[s] = attrQ[BYTE_SEL][NIB_LSB+1];
  end

  assign topRdNext = attrQ[0][TOP_CODE_LSB];
  assign topWrNext = attrQ[0][TOP_CODE_LSB+1];
  assign winNext   = smramQ[FORCE_BIT] | (strobe.smmState & smramQ[SMM_GATE_BIT]);

  logic [NUM_SEG-1:0] segRdQ, segWrQ;
  logic               topRdQ, topWrQ, winOpenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segRdQ   <= '0;
      segWrQ   <= '0;
      topRdQ   <= 1'b0;
      topWrQ   <= 1'b0;
      winOpenQ <= 1'b0;
    end else if (strobe.remap) begin
      segRdQ   <= segRdNext;
      segWrQ   <= segWrNext;
      topRdQ   <= topRdNext;
      topWrQ   <= topWrNext;
      winOpenQ <= winNext;
    end
  end

  // Lookup decode
  logic                 upperZero, inLegacy, isWin, isTop;
  logic [SEG_IDX_W-1:0] segIdx;
  logic                 hitDram;

  assign upperZero = (reqAddr[ADDR_W-1:WIN_TOP_BIT] == '0);
  assign inLegacy  = reqAddr[19] & (reqAddr[18] | reqAddr[17]);
  assign isWin     = (reqAddr[19:17] == 3'b101);
  assign isTop     = (reqAddr[19:16] == 4'hF);
  assign segIdx    = reqAddr[SEG_LSB+SEG_IDX_W-1:SEG_LSB];

  always_comb begin
    hitDram = 1'b1;
    if (upperZero && inLegacy) begin
      if (isWin)      hitDram = winOpenQ;
      else if (isTop) hitDram = reqWrite ? topWrQ : topRdQ;
      else            hitDram = reqWrite ? segWrQ[segIdx] : segRdQ[segIdx];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspDram  <= 1'b0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) rspDram <= hitDram;
    end
  end

endmodule

// File: rtl/legacy_attr_decoder.sv
module legacy_attr_decoder
  import legacy_attr_pkg::*;
#(
  parameter int         ADDR_W     = 32,
  parameter logic [7:0] ATTR_BASE  = 8'h59,
  parameter int         ATTR_BYTES = 7,
  parameter int         NUM_SEG    = 12,
  parameter logic [7:0] SMRAM_OFF  = 8'h72,
  parameter logic [7:0] SMRAM_RST  = 8'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgAddr,
  input  logic [7:0]        cfgData,
  input  logic              smmActive,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  output logic              rspValid,
  output logic              rspDram
);

  ctlStrobe_t strobe;

  legacy_attr_ctrl #(
    .ATTR_BASE (ATTR_BASE),
    .ATTR_BYTES(ATTR_BYTES),
    .SMRAM_OFF (SMRAM_OFF)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .smmActive(smmActive),
    .strobe   (strobe)
  );

  legacy_attr_dp #(
    .ADDR_W    (ADDR_W),
    .ATTR_BYTES(ATTR_BYTES),
    .NUM_SEG   (NUM_SEG),
    .SMRAM_RST (SMRAM_RST)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgData (cfgData),
    .reqValid(reqValid),
    .reqAddr (reqAddr),
    .reqWrite(reqWrite),
    .rspValid(rspValid),
    .rspDram (rspDram)
  );

endmodule

// File: rtl/legacy_attr_decoder_chk.sv
module legacy_attr_decoder_chk #(
  parameter int         ADDR_W    = 32,
  parameter logic [7:0] SMRAM_OFF = 8'h72
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [7:0]        cfgAddr,
  input logic              smmActive,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic              rspDram
);

  // Set once anything that could open the graphics area has been seen
  logic winTouched;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) winTouched <= 1'b0;
    else if ((cfgWrEn && cfgAddr == SMRAM_OFF) || smmActive) winTouched <= 1'b1;
  end

  logic reqOutside, reqInWin;
  assign reqOutside = (reqAddr >= ADDR_W'(32'h0010_0000)) || (reqAddr < ADDR_W'(32'h000A_0000));
  assign reqInWin   = (reqAddr >= ADDR_W'(32'h000A_0000)) && (reqAddr < ADDR_W'(32'h000C_0000));

  // R8: every lookup gets a response on the next cycle
  assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R8: no response without a lookup
  assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R7: outside the legacy window always DRAM
  assert_outside_dram_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOutside) |=> rspDram);

  // R1 / R5: graphics area stays on the bus until its control is touched
  assert_window_reset_bus_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqInWin && !winTouched) |=> !rspDram);

endmodule

bind legacy_attr_decoder legacy_attr_decoder_chk #(
  .ADDR_W   (ADDR_W),
  .SMRAM_OFF(SMRAM_OFF)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgWrEn  (cfgWrEn),
  .cfgAddr  (cfgAddr),
  .smmActive(smmActive),
  .reqValid (reqValid),
  .reqAddr  (reqAddr),
  .rspValid (rspValid),
  .rspDram  (rspDram)
);

// File: tb/tb_legacy_attr_decoder.sv
`timescale 1ns/1ps
module tb_legacy_attr_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [7:0]  cfgData = '0;
  logic        smmActive = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        rspValid;
  logic        rspDram;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;  // 250 MHz

  legacy_attr_decoder dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .smmActive(smmActive), .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .rspValid(rspValid), .rspDram(rspDram)
  );

  // Reference model state
  logic [7:0] attrM [7];
  logic [7:0] smramM;
  logic       smmM;

  // Scoreboard queues
  bit          expQ  [$];
  string       tagQ  [$];
  logic [31:0] addrQ [$];

  function automatic bit expDram(input logic [31:0] a, input bit wr);
    logic [1:0] code;
    int seg;
    if (a >= 32'h0010_0000 || a < 32'h000A_0000) return 1'b1;
    if (a < 32'h000C_0000) return smramM[6] | (smmM & smramM[3]);
    if (a >= 32'h000F_0000) code = attrM[0][5:4];
    else begin
      seg  = int'((a - 32'h000C_0000) >> 14);
      code = (seg % 2 == 1) ? attrM[1 + seg/2][5:4] : attrM[1 + seg/2][1:0];
    end
    return wr ? code[1] : code[0];
  endfunction

  task automatic cfgWriteRaw(input logic [7:0] a, input logic [7:0] d);
    cfgAddr = a; cfgData = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (a >= 8'h59 && a <= 8'h5F) attrM[a - 8'h59] = d;
    if (a == 8'h72) smramM = d;
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [7:0] d);
    cfgWriteRaw(a, d);
    repeat (2) @(negedge clk);
  endtask

  task automatic setSmm(input bit v);
    smmActive = v; smmM = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic lookupExp(input logic [31:0] a, input bit wr, input bit e, input string tag);
    expQ.push_back(e); tagQ.push_back(tag); addrQ.push_back(a);
    reqAddr = a; reqWrite = wr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] a, input bit wr, input string tag);
    lookupExp(a, wr, expDram(a, wr), tag);
  endtask

  // Monitor: pops expected items as responses appear
  always @(negedge clk) begin : monitor
    bit e; string t; logic [31:0] a;
    if (rstN && rspValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R8: response with no pending lookup, actual rspValid=1 expected 0");
      end else begin
        e = expQ.pop_front(); t = tagQ.pop_front(); a = addrQ.pop_front();
        if (rspDram !== e) begin
          errors++;
          $display("FAIL %s: addr=%h actual rspDram=%0b expected %0b", t, a, rspDram, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    bit oldE, newE;
    logic [7:0] b;
    for (int i = 0; i < 7; i++) attrM[i] = 8'h00;
    smramM = 8'h02; smmM = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checks++;
    if (rspValid !== 1'b0) begin
      errors++; $display("FAIL R1: actual rspValid=%0b expected 0", rspValid);
    end
    lookup(32'h000C_0000, 1'b0, "R1");
    lookup(32'h000E_FFFF, 1'b1, "R1");
    lookup(32'h000F_0000, 1'b0, "R1");
    lookup(32'h000A_0000, 1'b0, "R1");
    lookup(32'h000B_FFFF, 1'b1, "R1");

    // R2 / R4: top region, unrelated bits set
    cfgWrite(8'h59, 8'hCF);
    lookup(32'h000F_8000, 1'b0, "R2");
    lookup(32'h000F_8000, 1'b1, "R2");
    cfgWrite(8'h59, 8'h30);
    lookup(32'h000F_0000, 1'b0, "R4");
    lookup(32'h000F_FFFF, 1'b1, "R4");
    cfgWrite(8'h59, 8'h10);
    lookup(32'h000F_4000, 1'b0, "R4");
    lookup(32'h000F_4000, 1'b1, "R4");
    cfgWrite(8'h59, 8'h20);
    lookup(32'h000F_C000, 1'b0, "R4");
    lookup(32'h000F_C000, 1'b1, "R4");

    // R3 / R4: every segment with distinct codes, unused bits set
    for (int k = 0; k < 6; k++) begin
      int s0, s1;
      s0 = 2*k; s1 = 2*k + 1;
      b = 8'hCC | 8'((s0*3 + s0/4) % 4) | (8'((s1*3 + s1/4) % 4) << 4);
      cfgWrite(8'h5A + 8'(k), b);
    end
    for (int s = 0; s < 12; s++) begin
      logic [31:0] base;
      base = 32'h000C_0000 + 32'(s) * 32'h4000;
      lookup(base, 1'b0, "R3");
      lookup(base, 1'b1, "R3");
      lookup(base + 32'h3FFF, 1'b0, "R3");
      lookup(base + 32'h3FFF, 1'b1, "R3");
    end

    // R9: neighbouring offsets ignored
    cfgWrite(8'h58, 8'hFF);
    cfgWrite(8'h60, 8'hFF);
    cfgWrite(8'h71, 8'hFF);
    cfgWrite(8'h73, 8'hFF);
    cfgWrite(8'h00, 8'hFF);
    lookup(32'h000C_0000, 1'b0, "R9");
    lookup(32'h000E_C000, 1'b0, "R9");
    lookup(32'h000E_C000, 1'b1, "R9");
    lookup(32'h000F_0000, 1'b0, "R9");
    lookup(32'h000A_0000, 1'b0, "R9");

    // R5 / R6: graphics area
    cfgWrite(8'h72, 8'h40);
    lookup(32'h000A_0000, 1'b0, "R5");
    lookup(32'h000B_FFFF, 1'b1, "R5");
    cfgWrite(8'h72, 8'h08);
    lookup(32'h000A_8000, 1'b0, "R5");
    setSmm(1'b1);
    lookup(32'h000A_8000, 1'b0, "R6");
    lookup(32'h000B_0000, 1'b1, "R6");
    setSmm(1'b0);
    lookup(32'h000A_8000, 1'b1, "R6");
    cfgWrite(8'h72, 8'h00);
    setSmm(1'b1);
    lookup(32'h000A_0000, 1'b0, "R5");
    setSmm(1'b0);

    // R7: outside the window, including aliases of forwarded segments
    lookup(32'h0009_FFFF, 1'b0, "R7");
    lookup(32'h0000_0000, 1'b1, "R7");
    lookup(32'h0010_0000, 1'b0, "R7");
    lookup(32'h001C_0000, 1'b0, "R7");
    lookup(32'h800A_0000, 1'b1, "R7");
    lookup(32'hFFFF_FFFF, 1'b0, "R7");

    // R8: configuration write latency
    oldE = expDram(32'h000C_0000, 1'b0);
    cfgWriteRaw(8'h5A, attrM[1] ^ 8'h01);
    newE = expDram(32'h000C_0000, 1'b0);
    lookupExp(32'h000C_0000, 1'b0, oldE, "R8");
    lookupExp(32'h000C_0000, 1'b0, newE, "R8");

    // R8: SMM change latency
    cfgWrite(8'h72, 8'h08);
    smmActive = 1'b1; smmM = 1'b1;
    lookupExp(32'h000A_0000, 1'b0, 1'b0, "R8");
    lookupExp(32'h000A_0000, 1'b0, 1'b0, "R8");
    lookupExp(32'h000A_0000, 1'b0, 1'b1, "R8");

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R8: missing responses, actual pending=%0d expected 0", expQ.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule